// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block owns the reset and operating-mode logic of a small microcontroller. The bidirectional reset pin is active low and works in both directions. The block senses it as a level, and it can also pull the pin low through an open-drain enable. A falling edge seen on the pin, or a request from inside the chip, turns that pull-down on for a fixed number of state times. One state time is one clock period. The core is held in reset for as long as the synchronized pin reads low, or while the pull-down is active.

The controller tracks the operating mode: normal, idle, standby or powerdown. Software asks for a low-power mode through a request strobe. Standby and powerdown are only allowed when the low-power configuration bit is set. Any reset returns the mode to normal. An external interrupt line whose enable bit is set also returns it to normal, without a reset. When reset ends, the controller offers the reset fetch address on a valid/ready output. It holds that offer until the consumer takes it.

The block also decodes the two clock-multiplier enable inputs into a multiplier select. It flags the one combination that is not supported.

Top module: `rstmode_ctrl`

## Requirements
- R1: A falling edge on the synchronized reset pin, or a high `int_rst_req` sampled on a clock edge, drives `rst_pin_pd_en` high for exactly PD_STATES (default 16) consecutive cycles, starting the cycle after the trigger is sampled.
- R2: A new `int_rst_req` while the pull-down is active restarts the full PD_STATES count. Falling edges seen on the pin while the pull-down is active are ignored, whether they come from its own drive or from outside.
- R3: `core_rst` is high whenever the pin value after SYNC_STAGES flops is low, or `rst_pin_pd_en` is high.
- R4: One cycle after `core_rst` is high, `op_mode` is normal.
- R5: `op_mode` is encoded normal=0, idle=1, standby=2, powerdown=3. A request with `mode_req_valid` high is taken only while the mode is normal and the core is out of reset. The new mode shows one cycle later.
- R6: Requests for standby (2) or powerdown (3) are ignored when `lowpwr_cfg_en` is 0. A request for idle is always accepted.
- R7: In idle, standby or powerdown, an `ext_irq[i]` that is high while `irq_en[i]` is 1 returns `op_mode` to normal on the next cycle. An interrupt line whose enable bit is 0 has no effect.
- R8: The cycle after `core_rst` falls, `fetch_valid` rises with `fetch_addr` = 0xFF2080. It stays high until a cycle in which `fetch_ready` is high, or until `core_rst` rises again.
- R9: `mul_sel` decodes {`mul_en_a`,`mul_en_b`} as follows: 00 gives 0 (x1), 10 gives 1 (x2), 11 gives 2 (x4).
- R10: `mul_en_a`=0 with `mul_en_b`=1 raises `mul_test_mode`, and `mul_sel` reads 0 in that case.
- R11: While `por_n` is low, the outputs read: pull-down off, `core_rst` low, `op_mode` 0, `fetch_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Sensed level of the reset pin, active low |
| int_rst_req | input | 1 | Internal reset request |
| lowpwr_cfg_en | input | 1 | Configuration bit that permits standby and powerdown |
| irq_en | input | NIRQ | Per-line enable for the external interrupts (1 = enabled) |
| ext_irq | input | NIRQ | External interrupt lines used as wake sources |
| mode_req_valid | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode code |
| mul_en_a | input | 1 | Clock-multiplier enable A |
| mul_en_b | input | 1 | Clock-multiplier enable B |
| fetch_ready | input | 1 | Consumer accepts the reset fetch address |
| rst_pin_pd_en | output | 1 | Open-drain pull-down enable for the reset pin |
| core_rst | output | 1 | Reset to the core |
| op_mode | output | 2 | Current operating mode |
| fetch_valid | output | 1 | Reset fetch address offered |
| fetch_addr | output | ADDR_W | Reset fetch address |
| mul_sel | output | 2 | Multiplier select: 0 = x1, 1 = x2, 2 = x4 |
| mul_test_mode | output | 1 | Unsupported multiplier combination flagged |

## Verification
The bench builds the block with its default parameters: PD_STATES=16, SYNC_STAGES=2 and two interrupt lines. These values make the exact 16-cycle stretch, a restart partway through it, and the two-cycle sensing lag all visible within a short run. The bench models the pin as a wired-AND of its own external drive and the block's pull-down. This lets it show that the block's own drive does not retrigger the stretch, while a long external hold still keeps the core in reset.

// File: rtl/rstmode_pkg.sv
package rstmode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_PWRDN   = 2'd3
  } op_mode_t;

  localparam logic [1:0] MUL_X1 = 2'd0;
  localparam logic [1:0] MUL_X2 = 2'd1;
  localparam logic [1:0] MUL_X4 = 2'd2;
endpackage

// File: rtl/rstmode_pin_sense.sv
module rstmode_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic drive_active,
  output logic pin_lvl,
  output logic fall_evt
);
  // one flop beyond the synchronizer holds the previous level
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= pin_n;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign pin_lvl  = chain_q[SYNC_STAGES-1];
  assign fall_evt = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1] & ~drive_active;
endmodule

// File: rtl/rstmode_stretch.sv
module rstmode_stretch #(
  parameter int PD_STATES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic active
);
  localparam int CNT_W = $clog2(PD_STATES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PD_STATES);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 left_q <= '0;
    else if (trig)              left_q <= LOAD;
    else if (left_q != '0)      left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/rstmode_mode_fsm.sv
module rstmode_mode_fsm
  import rstmode_pkg::*;
#(
  parameter int NIRQ = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            hold_rst,
  input  logic            lowpwr_ok,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            req_valid,
  input  logic [1:0]      req,
  output op_mode_t        mode
);
  op_mode_t mode_q, mode_d;
  logic     wake;

  assign wake = |(irq & irq_en);

  always_comb begin
    mode_d = mode_q;
    if (hold_rst) begin
      mode_d = MODE_NORMAL;
    end else if (mode_q != MODE_NORMAL) begin
      if (wake) mode_d = MODE_NORMAL;
    end else if (req_valid) begin
      unique case (op_mode_t'(req))
        MODE_IDLE:    mode_d = MODE_IDLE;
        MODE_STANDBY: if (lowpwr_ok) mode_d = MODE_STANDBY;
        MODE_PWRDN:   if (lowpwr_ok) mode_d = MODE_PWRDN;
        default:      mode_d = MODE_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/rstmode_clkmul.sv
module rstmode_clkmul
  import rstmode_pkg::*;
(
  input  logic       en_a,
  input  logic       en_b,
  output logic [1:0] sel,
  output logic       bad_combo
);
  always_comb begin
    bad_combo = 1'b0;
    unique case ({en_a, en_b})
      2'b00:   sel = MUL_X1;
      2'b10:   sel = MUL_X2;
      2'b11:   sel = MUL_X4;
      default: begin
        sel       = MUL_X1;
        bad_combo = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rstmode_ctrl.sv
module rstmode_ctrl
  import rstmode_pkg::*;
#(
  parameter int          PD_STATES   = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          NIRQ        = 2,
  parameter int          ADDR_W      = 24,
  parameter logic [23:0] RESET_VEC   = 24'hFF2080
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              int_rst_req,
  input  logic              lowpwr_cfg_en,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic [NIRQ-1:0]   ext_irq,
  input  logic              mode_req_valid,
  input  logic [1:0]        mode_req,
  input  logic              mul_en_a,
  input  logic              mul_en_b,
  input  logic              fetch_ready,
  output logic              rst_pin_pd_en,
  output logic              core_rst,
  output logic [1:0]        op_mode,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        mul_sel,
  output logic              mul_test_mode
);
  logic     pin_lvl, pin_fall, pd_active, pd_trig;
  logic     rst_q, fv_q;
  op_mode_t mode;

  rstmode_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n),
    .drive_active(pd_active), .pin_lvl(pin_lvl), .fall_evt(pin_fall)
  );

  assign pd_trig = pin_fall | int_rst_req;

  rstmode_stretch #(.PD_STATES(PD_STATES)) u_stretch (
    .clk(clk), .por_n(por_n), .trig(pd_trig), .active(pd_active)
  );

  assign rst_pin_pd_en = pd_active;
  assign core_rst      = ~pin_lvl | pd_active;

  rstmode_mode_fsm #(.NIRQ(NIRQ)) u_mode (
    .clk(clk), .por_n(por_n), .hold_rst(core_rst), .lowpwr_ok(lowpwr_cfg_en),
    .irq(ext_irq), .irq_en(irq_en), .req_valid(mode_req_valid),
    .req(mode_req), .mode(mode)
  );

  assign op_mode = mode;

  // reset-exit fetch offer, held until accepted
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b1;
      fv_q  <= 1'b0;
    end else begin
      rst_q <= core_rst;
      if (core_rst)                fv_q <= 1'b0;
      else if (rst_q)              fv_q <= 1'b1;
      else if (fv_q && fetch_ready) fv_q <= 1'b0;
    end
  end

  assign fetch_valid = fv_q;
  assign fetch_addr  = ADDR_W'(RESET_VEC);

  rstmode_clkmul u_mul (
    .en_a(mul_en_a), .en_b(mul_en_b), .sel(mul_sel), .bad_combo(mul_test_mode)
  );
endmodule

// File: rtl/rstmode_chk.sv
module rstmode_chk #(
  parameter int PD_STATES = 16,
  parameter int NIRQ      = 2
) (
  input logic            clk,
  input logic            por_n,
  input logic            int_rst_req,
  input logic            lowpwr_cfg_en,
  input logic [NIRQ-1:0] irq_en,
  input logic [NIRQ-1:0] ext_irq,
  input logic            fetch_ready,
  input logic            rst_pin_pd_en,
  input logic            core_rst,
  input logic [1:0]      op_mode,
  input logic            fetch_valid,
  input logic [1:0]      mul_sel,
  input logic            mul_test_mode
);
  localparam int RUN_W = $clog2(PD_STATES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         run_q <= '0;
    else if (rst_pin_pd_en && !int_rst_req) run_q <= run_q + 1'b1;
    else                                run_q <= '0;
  end

  // R1
  pd_len_max_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_pd_en |-> run_q < RUN_W'(PD_STATES));
  // R1
  pd_len_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_pin_pd_en) |-> run_q == RUN_W'(PD_STATES));
  // R2
  pd_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    int_rst_req |=> rst_pin_pd_en);
  // R3
  rst_cover_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_pd_en |-> core_rst);
  // R4
  rst_normal_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> op_mode == 2'd0);
  // R6
  no_deep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (op_mode == 2'd0 && !lowpwr_cfg_en) |=> op_mode <= 2'd1);
  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (op_mode != 2'd0 && (|(ext_irq & irq_en))) |=> op_mode == 2'd0);
  // R8
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (fetch_valid && !fetch_ready && !core_rst) |=> fetch_valid);
  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    mul_sel != 2'd3);
  // R10
  test_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
    mul_test_mode |-> mul_sel == 2'd0);
endmodule

bind rstmode_ctrl rstmode_chk #(.PD_STATES(PD_STATES), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .por_n(por_n), .int_rst_req(int_rst_req),
  .lowpwr_cfg_en(lowpwr_cfg_en), .irq_en(irq_en), .ext_irq(ext_irq),
  .fetch_ready(fetch_ready), .rst_pin_pd_en(rst_pin_pd_en),
  .core_rst(core_rst), .op_mode(op_mode), .fetch_valid(fetch_valid),
  .mul_sel(mul_sel), .mul_test_mode(mul_test_mode)
);

// File: tb/tb_rstmode_ctrl.sv
module tb_rstmode_ctrl;
  localparam int PD = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n = 1'b0, ext_n = 1'b1, int_req = 1'b0, cfg = 1'b0;
  logic [1:0] ien = 2'b00, irq = 2'b00, req = 2'b00;
  logic req_v = 1'b0, en_a = 1'b0, en_b = 1'b0, rdy = 1'b0;
  logic pd_en, crst, fv, tflag;
  logic [1:0] mode, msel;
  logic [23:0] faddr;
  wire  pin_n = ext_n & ~pd_en;

  rstmode_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(pin_n), .int_rst_req(int_req),
    .lowpwr_cfg_en(cfg), .irq_en(ien), .ext_irq(irq), .mode_req_valid(req_v),
    .mode_req(req), .mul_en_a(en_a), .mul_en_b(en_b), .fetch_ready(rdy),
    .rst_pin_pd_en(pd_en), .core_rst(crst), .op_mode(mode), .fetch_valid(fv),
    .fetch_addr(faddr), .mul_sel(msel), .mul_test_mode(tflag)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  bit s1 = 1, s2 = 1, s3 = 1, m_rq = 1, m_fv = 0;
  int m_cnt = 0, m_mode = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1 = 1; s2 = 1; s3 = 1; m_rq = 1; m_fv = 0; m_cnt = 0; m_mode = 0;
    end else begin
      bit pin, fall, trig, cr, wake;
      pin  = ext_n && (m_cnt == 0);
      fall = s3 && !s2 && (m_cnt == 0);
      trig = int_req || fall;
      cr   = !s2 || (m_cnt > 0);
      wake = (irq & ien) != 0;
      if (cr) m_mode = 0;
      else if (m_mode != 0) begin if (wake) m_mode = 0; end
      else if (req_v) begin
        if (req == 1) m_mode = 1;
        else if (req >= 2 && cfg) m_mode = req;
      end
      if (cr) m_fv = 0;
      else if (m_rq) m_fv = 1;
      else if (m_fv && rdy) m_fv = 0;
      m_rq  = cr;
      m_cnt = trig ? PD : (m_cnt > 0 ? m_cnt - 1 : 0);
      s3 = s2; s2 = s1; s1 = pin;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #4;
    if (!done) begin
      int esel, eflag;
      eflag = (!en_a && en_b) ? 1 : 0;
      esel  = (en_a && en_b) ? 2 : (en_a && !en_b) ? 1 : 0;
      chk("R1 R2 pull-down", int'(pd_en), int'(m_cnt > 0));
      chk("R3 core_rst", int'(crst), int'(!s2 || m_cnt > 0));
      chk("R4 R5 R6 R7 op_mode", int'(mode), m_mode);
      chk("R8 fetch_valid", int'(fv), int'(m_fv));
      chk("R8 fetch_addr", int'(faddr), 24'hFF2080);
      chk("R9 mul_sel", int'(msel), esel);
      chk("R10 test flag", int'(tflag), eflag);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ask(input logic [1:0] m);
    req = m; req_v = 1'b1; cyc(1); req_v = 1'b0; cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(1);
    // R11 reset state while por_n low
    chk("R11 pd", int'(pd_en), 0);
    chk("R11 core_rst", int'(crst), 0);
    chk("R11 mode", int'(mode), 0);
    chk("R11 fetch_valid", int'(fv), 0);
    cyc(2); por_n = 1'b1;
    cyc(4);                       // fetch offered, consumer stalls (R8)
    rdy = 1'b1; cyc(1); rdy = 1'b0; cyc(1);
    // R9 R10 every multiplier combination
    en_a = 1; en_b = 0; cyc(1);
    en_a = 1; en_b = 1; cyc(1);
    en_a = 0; en_b = 1; cyc(1);
    en_a = 0; en_b = 0; cyc(1);
    // R5 idle, R7 masked then unmasked wake
    ask(2'd1);
    irq = 2'b10; ien = 2'b01; cyc(3);
    ien = 2'b11; cyc(2); irq = 2'b00; cyc(1);
    // R6 deep modes refused without config bit
    ask(2'd2); ask(2'd3);
    cfg = 1'b1; ask(2'd2);
    ask(2'd1);                    // R5 ignored outside normal
    ien = 2'b01; irq = 2'b01; cyc(2); irq = 2'b00; cyc(1);
    // powerdown then external reset pulse (R1 R3 R4)
    ask(2'd3);
    ext_n = 1'b0; cyc(3); ext_n = 1'b1; cyc(24);
    rdy = 1'b1; cyc(2); rdy = 1'b0;
    // R2 internal request restarts the stretch
    int_req = 1'b1; cyc(1); int_req = 1'b0; cyc(5);
    int_req = 1'b1; cyc(1); int_req = 1'b0; cyc(22);
    // R2 external edge during the pull-down is not a retrigger
    int_req = 1'b1; cyc(1); int_req = 1'b0; cyc(6);
    ext_n = 1'b0; cyc(2); ext_n = 1'b1; cyc(22);
    // R3 long external hold keeps the core in reset
    ask(2'd1);
    ext_n = 1'b0; cyc(30); ext_n = 1'b1; cyc(6);
    rdy = 1'b1; cyc(3);
    finish_run();
  end
endmodule